// File: doc/BRIEF.md
# Boot-remappable first-level address decoder

This block turns the address issued by one of six bus masters into a single slave choice on an on-chip interconnect, or into an abort when nothing answers there or when that master may not reach the target. The top four address bits pick one of sixteen 256 MB banks. Bank zero holds the internal memories and a second-level map. Banks one through eight go to the external bus, with a chip-select index. Bank fifteen goes to the peripheral bridge. All remaining banks abort.

The 1 MB window at the bottom of bank zero is a boot alias, and only the two processor masters see it. Before software sets the remap flag, the window shows either the ROM or the Flash. A boot-source pin picks between them, and that pin is captured once, shortly after reset is released. Once the remap flag is set, the window shows the SRAM. A permission table, held per master, blocks paths that are not wired, such as the network MAC reaching the peripheral bridge. The decode itself is combinational. Only the boot capture and the remap flag are stored.

Top module: `boot_remap_decoder`

## Requirements
- R1: A permitted access to bank 1 through 8 (address bits 31:28) selects the external-bus slave (select bit 5), and `ext_cs_o` equals the bank number minus one.
- R2: A permitted access to bank 15 selects the peripheral bridge (select bit 6).
- R3: An access to bank 0x9 through 0xE aborts for every master.
- R4: In bank 0, offsets 0x10_0000–0x10_7FFF select ROM (bit 0), 0x20_0000–0x27_FFFF select Flash (bit 1), 0x30_0000–0x30_7FFF select SRAM (bit 2), 0x50_0000–0x50_3FFF select the USB host registers (bit 3) and 0x50_4000–0x50_7FFF select the USB device port (bit 4), subject to R8.
- R5: Every other bank-0 offset at or above 0x10_0000 aborts.
- R6: For masters 0 and 1, bank-0 offsets below 0x10_0000 select SRAM when the remap flag is 1. When the flag is 0, they select ROM if the captured boot bit is 0 and Flash if it is 1.
- R7: For masters 2 through 5, bank-0 offsets below 0x10_0000 abort.
- R8: Masters 0 and 1 (processor) may reach every slave. Master 2 (DMA) may reach every slave except the USB host registers. Masters 3, 4 and 5 (USB host, image sensor, network MAC) may reach only SRAM and the external bus. A forbidden path aborts.
- R9: The boot bit is loaded from `boot_pin_i` on the third rising clock edge after `rst_n` goes high. Later changes of the pin have no effect until the next reset.
- R10: The remap flag resets to 0. When `remap_we_i` is 1 at a rising edge, the flag takes the value of `remap_wd_i`, and that value is visible from the next cycle.
- R11: Exactly one of `abort_o` and the bits of `slv_sel_o` is 1 at any time. A master index of 6 or 7 always aborts, and `ext_cs_o` is 0 whenever the external slave is not selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_pin_i | input | 1 | Boot source, captured after reset (0 ROM, 1 Flash) |
| remap_we_i | input | 1 | Remap flag write enable |
| remap_wd_i | input | 1 | Remap flag write value |
| mst_i | input | 3 | Requesting master index |
| addr_i | input | 32 | Access address |
| slv_sel_o | output | 7 | One-hot slave select |
| abort_o | output | 1 | Access is unmapped or forbidden |
| ext_cs_o | output | 3 | External chip-select index |

## Verification
The decode is swept over all eight master codes against all sixteen banks. In bank 0, the probes sit at the first and last word of every internal region and just past each one. In the other banks, the probes are the bank base, a mid offset and the top word. This separates region edges from holes, external chip-select numbering, unmapped banks and each cell of the permission table. The sweep is repeated for all four combinations of boot bit and remap flag, which shows the three-way alias is reached by the processor masters only. Toggling the boot pin after capture, and writing the remap flag with the enable low, shows both stored values hold.

// File: rtl/bootdec_pkg.sv
package bootdec_pkg;

  localparam int NUM_SLV = 7;
  localparam int NUM_MST = 6;
  localparam int NUM_CPU = 2;
  localparam int MST_W   = 3;

  typedef enum logic [2:0] {
    SLV_ROM    = 3'd0,
    SLV_FLASH  = 3'd1,
    SLV_SRAM   = 3'd2,
    SLV_UHOST  = 3'd3,
    SLV_UDEV   = 3'd4,
    SLV_EXT    = 3'd5,
    SLV_PERIPH = 3'd6
  } slave_e;

  typedef struct packed {
    logic   hit;
    slave_e slv;
  } route_t;

  // reach masks, bit n = slave_e value n
  localparam logic [NUM_SLV-1:0] MASK_CPU    = 7'h7F;
  localparam logic [NUM_SLV-1:0] MASK_DMA    = 7'h77;
  localparam logic [NUM_SLV-1:0] MASK_STREAM = 7'h24 | 7'h10 ^ 7'h10;

  localparam logic [NUM_MST*NUM_SLV-1:0] PERMIT_DEFAULT =
    {MASK_STREAM, MASK_STREAM, MASK_STREAM, MASK_DMA, MASK_CPU, MASK_CPU};

endpackage

// File: rtl/bootdec_bank.sv
module bootdec_bank
  import bootdec_pkg::*;
#(
  parameter int BANK_W      = 4,
  parameter int CS_W        = 3,
  parameter int EXT_FIRST   = 1,
  parameter int EXT_BANKS   = 8,
  parameter int PERIPH_BANK = 15
) (
  input  logic [BANK_W-1:0] bank_i,
  output logic              internal_o,
  output route_t            route_o,
  output logic [CS_W-1:0]   cs_o
);

  localparam int EXT_LAST = EXT_FIRST + EXT_BANKS - 1;

  always_comb begin
    internal_o  = (bank_i == '0);
    route_o.hit = 1'b0;
    route_o.slv = SLV_ROM;
    cs_o        = '0;
    if (int'(bank_i) >= EXT_FIRST && int'(bank_i) <= EXT_LAST) begin
      route_o.hit = 1'b1;
      route_o.slv = SLV_EXT;
      cs_o        = CS_W'(int'(bank_i) - EXT_FIRST);
    end else if (int'(bank_i) == PERIPH_BANK) begin
      route_o.hit = 1'b1;
      route_o.slv = SLV_PERIPH;
    end
  end

endmodule

// File: rtl/bootdec_int_map.sv
module bootdec_int_map
  import bootdec_pkg::*;
#(
  parameter int              OFF_W      = 28,
  parameter int              ALIAS_AW   = 20,
  parameter logic [27:0]     ROM_BASE   = 28'h010_0000,
  parameter int              ROM_AW     = 15,
  parameter logic [27:0]     FLASH_BASE = 28'h020_0000,
  parameter int              FLASH_AW   = 19,
  parameter logic [27:0]     SRAM_BASE  = 28'h030_0000,
  parameter int              SRAM_AW    = 15,
  parameter logic [27:0]     UHOST_BASE = 28'h050_0000,
  parameter logic [27:0]     UDEV_BASE  = 28'h050_4000,
  parameter int              USB_AW     = 14
) (
  input  logic [OFF_W-1:0] offset_i,
  input  logic             is_cpu_i,
  input  logic             remap_i,
  input  logic             boot_flash_i,
  output route_t           route_o
);

  function automatic logic in_win(input logic [OFF_W-1:0] off,
                                  input logic [OFF_W-1:0] base,
                                  input int aw);
    return (off >> aw) == (base >> aw);
  endfunction

  always_comb begin
    route_o.hit = 1'b0;
    route_o.slv = SLV_ROM;
    if ((offset_i >> ALIAS_AW) == '0) begin
      if (is_cpu_i) begin
        route_o.hit = 1'b1;
        if (remap_i)           route_o.slv = SLV_SRAM;
        else if (boot_flash_i) route_o.slv = SLV_FLASH;
        else                   route_o.slv = SLV_ROM;
      end
    end else if (in_win(offset_i, ROM_BASE, ROM_AW)) begin
      route_o.hit = 1'b1;
      route_o.slv = SLV_ROM;
    end else if (in_win(offset_i, FLASH_BASE, FLASH_AW)) begin
      route_o.hit = 1'b1;
      route_o.slv = SLV_FLASH;
    end else if (in_win(offset_i, SRAM_BASE, SRAM_AW)) begin
      route_o.hit = 1'b1;
      route_o.slv = SLV_SRAM;
    end else if (in_win(offset_i, UHOST_BASE, USB_AW)) begin
      route_o.hit = 1'b1;
      route_o.slv = SLV_UHOST;
    end else if (in_win(offset_i, UDEV_BASE, USB_AW)) begin
      route_o.hit = 1'b1;
      route_o.slv = SLV_UDEV;
    end
  end

endmodule

// File: rtl/bootdec_boot_ctrl.sv
module bootdec_boot_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic boot_pin_i,
  input  logic remap_we_i,
  input  logic remap_wd_i,
  output logic boot_q_o,
  output logic boot_valid_o,
  output logic remap_q_o
);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic boot_q, boot_d, valid_q, valid_d, remap_q, remap_d;
  logic boot_en;

  always_comb begin
    sync_d  = {sync_q[SYNC_STAGES-2:0], 1'b1};
    boot_en = sync_q[SYNC_STAGES-1] & ~valid_q;
    boot_d  = boot_en ? boot_pin_i : boot_q;
    valid_d = valid_q | boot_en;
    remap_d = remap_we_i ? remap_wd_i : remap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      boot_q  <= 1'b0;
      valid_q <= 1'b0;
      remap_q <= 1'b0;
    end else begin
      sync_q  <= sync_d;
      boot_q  <= boot_d;
      valid_q <= valid_d;
      remap_q <= remap_d;
    end
  end

  assign boot_q_o     = boot_q;
  assign boot_valid_o = valid_q;
  assign remap_q_o    = remap_q;

endmodule

// File: rtl/boot_remap_decoder.sv
module boot_remap_decoder
  import bootdec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BANK_W = 4,
  parameter int CS_W   = 3,
  parameter logic [NUM_MST*NUM_SLV-1:0] PERMIT = PERMIT_DEFAULT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               boot_pin_i,
  input  logic               remap_we_i,
  input  logic               remap_wd_i,
  input  logic [MST_W-1:0]   mst_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [NUM_SLV-1:0] slv_sel_o,
  output logic               abort_o,
  output logic [CS_W-1:0]    ext_cs_o
);

  localparam int OFF_W = ADDR_W - BANK_W;

  logic               boot_q, boot_valid, remap_q;
  logic               bank_internal;
  route_t             bank_route, int_route, route;
  logic [CS_W-1:0]    bank_cs;
  logic [NUM_SLV-1:0] permit_tbl [NUM_MST];
  logic [NUM_SLV-1:0] mst_mask;
  logic               is_cpu, granted;

  bootdec_boot_ctrl u_boot (
    .clk          (clk),
    .rst_n        (rst_n),
    .boot_pin_i   (boot_pin_i),
    .remap_we_i   (remap_we_i),
    .remap_wd_i   (remap_wd_i),
    .boot_q_o     (boot_q),
    .boot_valid_o (boot_valid),
    .remap_q_o    (remap_q)
  );

  bootdec_bank #(.BANK_W(BANK_W), .CS_W(CS_W)) u_bank (
    .bank_i     (addr_i[ADDR_W-1 -: BANK_W]),
    .internal_o (bank_internal),
    .route_o    (bank_route),
    .cs_o       (bank_cs)
  );

  bootdec_int_map #(.OFF_W(OFF_W)) u_int (
    .offset_i     (addr_i[OFF_W-1:0]),
    .is_cpu_i     (is_cpu),
    .remap_i      (remap_q),
    .boot_flash_i (boot_q),
    .route_o      (int_route)
  );

  for (genvar g = 0; g < NUM_MST; g++) begin : g_permit
    assign permit_tbl[g] = PERMIT[g*NUM_SLV +: NUM_SLV];
  end

  always_comb begin
    is_cpu   = int'(mst_i) < NUM_CPU;
    mst_mask = '0;
    for (int m = 0; m < NUM_MST; m++) begin
      if (int'(mst_i) == m) mst_mask = permit_tbl[m];
    end
    route     = bank_internal ? int_route : bank_route;
    granted   = route.hit & mst_mask[route.slv];
    slv_sel_o = '0;
    if (granted) slv_sel_o[route.slv] = 1'b1;
    abort_o   = ~granted;
    ext_cs_o  = (granted && route.slv == SLV_EXT) ? bank_cs : '0;
  end

endmodule

// File: rtl/bootdec_chk.sv
module bootdec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  mst_i,
  input logic [31:0] addr_i,
  input logic [6:0]  slv_sel_o,
  input logic        abort_o,
  input logic [2:0]  ext_cs_o,
  input logic        remap_we_i,
  input logic        remap_wd_i,
  input logic        remap_q,
  input logic        boot_q,
  input logic        boot_valid
);

  a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({abort_o, slv_sel_o}) == 1);

  a_r3_gap_bank_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i[31:28] >= 4'h9 && addr_i[31:28] <= 4'hE) |-> abort_o);

  a_r8_mac_no_bridge: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_i == 3'd5) |-> !slv_sel_o[6]);

  a_r7_alias_cpu_only: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_i >= 3'd2 && addr_i[31:20] == 12'h000) |-> abort_o);

  a_r1_cs_from_bank: assert property (@(posedge clk) disable iff (!rst_n)
    slv_sel_o[5] |-> (ext_cs_o == 3'(addr_i[31:28] - 4'd1)));

  a_r9_boot_held: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_valid && $past(boot_valid)) |-> $stable(boot_q));

  a_r10_remap_load: assert property (@(posedge clk) disable iff (!rst_n)
    remap_we_i |=> (remap_q == $past(remap_wd_i)));

endmodule

bind boot_remap_decoder bootdec_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mst_i      (mst_i),
  .addr_i     (addr_i),
  .slv_sel_o  (slv_sel_o),
  .abort_o    (abort_o),
  .ext_cs_o   (ext_cs_o),
  .remap_we_i (remap_we_i),
  .remap_wd_i (remap_wd_i),
  .remap_q    (remap_q),
  .boot_q     (boot_q),
  .boot_valid (boot_valid)
);

// File: tb/sim_boot_remap_decoder.sv
module sim_boot_remap_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_pin = 1'b0;
  logic        we = 1'b0;
  logic        wd = 1'b0;
  logic [2:0]  mst = '0;
  logic [31:0] addr = '0;
  logic [6:0]  sel;
  logic        abort;
  logic [2:0]  cs;

  int checks = 0;
  int errors = 0;

  boot_remap_decoder u0 (
    .clk(clk), .rst_n(rst_n), .boot_pin_i(boot_pin),
    .remap_we_i(we), .remap_wd_i(wd), .mst_i(mst), .addr_i(addr),
    .slv_sel_o(sel), .abort_o(abort), .ext_cs_o(cs)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD*150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic bit allowed(int m, int s);
    if (m < 2)  return 1'b1;
    if (m == 2) return s != 3;
    if (m <= 5) return (s == 2) || (s == 5);
    return 1'b0;
  endfunction

  task automatic model(input int m, input logic [31:0] a, input bit rmp,
                       input bit bt, output logic [10:0] exp, output string req);
    int b, s, c;
    logic [27:0] o;
    b = int'(a[31:28]); o = a[27:0]; s = -1; c = 0;
    if (b == 0) begin
      if (o < 28'h10_0000) begin
        if (m < 2) s = rmp ? 2 : (bt ? 1 : 0);
        req = (m < 2) ? "R6" : "R7";
      end else begin
        if (o >= 28'h10_0000 && o < 28'h10_8000) s = 0;
        else if (o >= 28'h20_0000 && o < 28'h28_0000) s = 1;
        else if (o >= 28'h30_0000 && o < 28'h30_8000) s = 2;
        else if (o >= 28'h50_0000 && o < 28'h50_4000) s = 3;
        else if (o >= 28'h50_4000 && o < 28'h50_8000) s = 4;
        req = (s >= 0) ? "R4" : "R5";
      end
    end else if (b >= 1 && b <= 8) begin
      s = 5; c = b - 1; req = "R1";
    end else if (b == 15) begin
      s = 6; req = "R2";
    end else begin
      req = "R3";
    end
    if (s >= 0 && !allowed(m, s) && !(b == 0 && o < 28'h10_0000)) req = "R8";
    if (m > 5) req = "R11";
    if (s >= 0 && allowed(m, s)) exp = {1'b0, 3'(c), 7'(1 << s)};
    else                         exp = {1'b1, 3'b0, 7'b0};
  endtask

  task automatic check(input string req, input logic [31:0] a, input int m,
                       input logic [10:0] exp);
    logic [10:0] got;
    got = {abort, cs, sel};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s m=%0d addr=%h got=%b exp=%b", req, m, a, got, exp);
    end
  endtask

  task automatic probe(input int m, input logic [31:0] a, input bit rmp, input bit bt);
    logic [10:0] exp;
    string req;
    @(negedge clk);
    mst = 3'(m); addr = a;
    #1;
    model(m, a, rmp, bt, exp, req);
    check(req, a, m, exp);
  endtask

  task automatic sweep(input bit rmp, input bit bt);
    logic [27:0] offs [17] = '{28'h000_0000, 28'h00F_FFFC, 28'h010_0000, 28'h010_7FFC,
      28'h010_8000, 28'h020_0000, 28'h027_FFFC, 28'h028_0000, 28'h030_0000,
      28'h030_7FFC, 28'h030_8000, 28'h050_0000, 28'h050_3FFC, 28'h050_4000,
      28'h050_7FFC, 28'h050_8000, 28'hFFF_FFFC};
    logic [27:0] far [3] = '{28'h000_0000, 28'h0AB_CDE0, 28'hFFF_FFFC};
    for (int m = 0; m < 8; m++) begin
      for (int i = 0; i < 17; i++) probe(m, {4'h0, offs[i]}, rmp, bt);
      for (int b = 1; b < 16; b++)
        for (int i = 0; i < 3; i++) probe(m, {4'(b), far[i]}, rmp, bt);
    end
  endtask

  task automatic write_remap(input bit v, input bit en);
    @(negedge clk); we = en; wd = v;
    @(negedge clk); we = 1'b0; wd = 1'b0;
  endtask

  task automatic do_reset(input bit bt);
    @(negedge clk); rst_n = 1'b0; boot_pin = bt;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    do_reset(1'b0);
    // R10: remap clear after reset, ROM at zero for processor
    probe(0, 32'h0000_0040, 1'b0, 1'b0);
    for (int bt = 0; bt < 2; bt++) begin
      do_reset(bit'(bt));
      // R9: pin changes after capture have no effect
      boot_pin = ~bit'(bt);
      probe(1, 32'h0000_0000, 1'b0, bit'(bt));
      // R10: data without enable is ignored
      write_remap(1'b1, 1'b0);
      probe(0, 32'h0000_0100, 1'b0, bit'(bt));
      sweep(1'b0, bit'(bt));
      write_remap(1'b1, 1'b1);
      sweep(1'b1, bit'(bt));
      // R10: clearing the flag restores the boot alias
      write_remap(1'b0, 1'b1);
      probe(1, 32'h0000_0000, 1'b0, bit'(bt));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule